// File: doc/BRIEF.md
# Fieldbus-Fed JTAG Pattern Player

This block reprograms a neighbouring device through its JTAG Test Access Port. Software on the bus master turns a programming file into raw pin patterns and sends them in a received fieldbus variable. The block then plays those patterns onto TCK, TMS and TDI. It captures the target's TDO answer once per TCK period and writes the answer into the reply variable buffer. The master reads that buffer back and compares it with the expected response.

The received buffer is read through a combinational read port. Byte 0 holds the number of TMS/TDI pairs, N. The pairs follow from byte 1 onward, four to a byte. The reply buffer is filled through a single-cycle write strobe.

A one-cycle start pulse begins a run. While busy is high, the surrounding node keeps its normal data exchange suspended. A one-cycle done pulse marks the end of the run.

Top module: `jtag_bit_player`

## Requirements
- R1: After reset, tck, tms, tdi, busy, done and tx_we are all low.
- R2: A start pulse sampled while idle reads the byte at rx_addr 0 as the pair count N and latches tck_half. busy is high from the next cycle onward.
- R3: Pair k is stored in received byte 1+floor(k/4). Its TMS is bit 2*(k mod 4)+1 and its TDI is bit 2*(k mod 4). Pairs are played in increasing k.
- R4: Let H be tck_half, or 1 when tck_half is 0. Each pair takes 2H clock cycles: TCK is low for H cycles and then high for H cycles. The first low phase begins two cycles after the start edge.
- R5: TMS and TDI change only while TCK is low, at the TCK falling edge. They hold for the whole TCK period of their pair.
- R6: TDO is sampled at the clock edge on which TCK rises. The sampled value is the one present before that rise.
- R7: Captured bit k goes to bit (k mod 8) of reply byte floor(k/8). tx_we pulses for one cycle, together with the TCK rise, when a byte fills or when the final bit is captured. Unused bits of the last byte are zero.
- R8: After the last falling TCK edge, done is high for exactly one cycle. In that same cycle busy drops and TCK is low.
- R9: When N is 0, the run produces no TCK edges and no writes. done pulses two cycles after the start edge.
- R10: A start pulse or a change of tck_half while busy has no effect on the run in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to begin a run |
| tck_half | input | DIV_W | TCK half period in clock cycles (0 acts as 1) |
| rx_addr | output | AW | Read address into the received buffer |
| rx_data | input | 8 | Byte read from the received buffer (combinational) |
| tx_we | output | 1 | Write strobe into the reply buffer |
| tx_addr | output | AW | Reply buffer byte address |
| tx_data | output | 8 | Reply buffer write data |
| tck | output | 1 | JTAG test clock to the target |
| tms | output | 1 | JTAG mode select to the target |
| tdi | output | 1 | JTAG data to the target |
| tdo | input | 1 | JTAG data from the target |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle end-of-run pulse |

## Verification
Every output is due at a fixed cycle count t after the start edge. For N>0 and t between 1 and 2HN, the run is in pair floor((t-1)/2H) and at phase (t-1) mod 2H. TCK is high for phases H and above. The write strobe appears at phase H, and done appears at t=2HN+1. For N=0, done appears at t=1.

The bench computes these times from N and H alone and samples every output on the falling clock edge after each rising edge. A target model changes TDO only after each TCK rise, so the bit that is due in each reply byte is known. The reply buffer is compared after each run, including a check that nothing was written past the last byte.

// File: rtl/jbp_pkg.sv
package jbp_pkg;
    localparam int unsigned CNT_W          = 8;
    localparam int unsigned PAIRS_PER_BYTE = 4;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_LAUNCH = 2'd1,
        ST_RUN    = 2'd2
    } jbp_state_e;
endpackage

// File: rtl/jbp_tck_timer.sv
module jbp_tck_timer #(
    parameter int unsigned DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic [DIV_W-1:0] half,
    output logic             expired
);
    logic [DIV_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (restart)
            cnt_d = half - DIV_W'(1);
        else if (cnt_q != '0)
            cnt_d = cnt_q - DIV_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = (cnt_q == '0);

    // phase counter never reaches the half period it counts down from
    assert_timer_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (half != '0) |-> (cnt_q < half));
endmodule

// File: rtl/jbp_pair_pick.sv
module jbp_pair_pick (
    input  logic [7:0] byte_i,
    input  logic [1:0] sel_i,
    output logic       tms_o,
    output logic       tdi_o
);
    logic [3:0] tms_lane, tdi_lane;

    for (genvar g = 0; g < 4; g++) begin : g_lane
        assign tms_lane[g] = byte_i[2*g+1];
        assign tdi_lane[g] = byte_i[2*g];
    end

    assign tms_o = tms_lane[sel_i];
    assign tdi_o = tdi_lane[sel_i];
endmodule

// File: rtl/jbp_tdo_packer.sv
module jbp_tdo_packer #(
    parameter int unsigned AW = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          cap_en,
    input  logic          bit_i,
    input  logic          last_i,
    output logic          we_o,
    output logic [AW-1:0] addr_o,
    output logic [7:0]    data_o
);
    typedef struct packed {
        logic [7:0]    acc;
        logic [2:0]    pos;
        logic [AW-1:0] next_addr;
        logic          we;
        logic [AW-1:0] addr;
        logic [7:0]    data;
    } pack_regs_t;

    pack_regs_t d, q;
    logic [7:0] merged;

    always_comb begin
        d      = q;
        d.we   = 1'b0;
        merged = q.acc | (8'(bit_i) << q.pos);
        if (clear) begin
            d.acc       = '0;
            d.pos       = '0;
            d.next_addr = '0;
        end else if (cap_en) begin
            if (q.pos == 3'd7 || last_i) begin
                d.we        = 1'b1;
                d.data      = merged;
                d.addr      = q.next_addr;
                d.next_addr = q.next_addr + AW'(1);
                d.acc       = '0;
                d.pos       = '0;
            end else begin
                d.acc = merged;
                d.pos = q.pos + 3'd1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign we_o   = q.we;
    assign addr_o = q.addr;
    assign data_o = q.data;

    // captures are at least two cycles apart, so a strobe never repeats back to back
    assert_we_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        q.we |=> !q.we);
    // a byte write always follows a capture in the previous cycle
    assert_we_after_cap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        q.we |-> $past(cap_en));
endmodule

// File: rtl/jtag_bit_player.sv
module jtag_bit_player #(
    parameter int unsigned BUF_BYTES = 124,
    parameter int unsigned DIV_W     = 8,
    localparam int unsigned AW       = $clog2(BUF_BYTES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [DIV_W-1:0] tck_half,
    output logic [AW-1:0]    rx_addr,
    input  logic [7:0]       rx_data,
    output logic             tx_we,
    output logic [AW-1:0]    tx_addr,
    output logic [7:0]       tx_data,
    output logic             tck,
    output logic             tms,
    output logic             tdi,
    input  logic             tdo,
    output logic             busy,
    output logic             done
);
    import jbp_pkg::*;

    typedef struct packed {
        jbp_state_e       state;
        logic             tck;
        logic             tms;
        logic             tdi;
        logic             done;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] idx;
        logic [DIV_W-1:0] half;
    } top_regs_t;

    top_regs_t d, q;

    logic             phase_end;
    logic             timer_restart;
    logic             pick_tms, pick_tdi;
    logic             all_issued;
    logic             cap_en;
    logic             accept;
    logic [DIV_W-1:0] half_eff;

    assign half_eff   = (tck_half == '0) ? DIV_W'(1) : tck_half;
    assign all_issued = (q.idx == q.cnt);
    assign accept     = (q.state == ST_IDLE) && start;
    assign cap_en     = (q.state == ST_RUN) && !q.tck && phase_end;
    assign rx_addr    = (q.state == ST_IDLE) ? '0
                      : AW'(1) + AW'(q.idx[CNT_W-1:2]);

    jbp_pair_pick u_pick (
        .byte_i (rx_data),
        .sel_i  (q.idx[1:0]),
        .tms_o  (pick_tms),
        .tdi_o  (pick_tdi)
    );

    always_comb begin
        d             = q;
        d.done        = 1'b0;
        timer_restart = 1'b0;
        unique case (q.state)
            ST_IDLE: begin
                if (start) begin
                    d.state = ST_LAUNCH;
                    d.cnt   = rx_data;
                    d.half  = half_eff;
                    d.idx   = '0;
                end
            end
            ST_LAUNCH: begin
                if (all_issued) begin
                    d.state = ST_IDLE;
                    d.done  = 1'b1;
                end else begin
                    d.tms         = pick_tms;
                    d.tdi         = pick_tdi;
                    d.idx         = q.idx + CNT_W'(1);
                    d.state       = ST_RUN;
                    timer_restart = 1'b1;
                end
            end
            ST_RUN: begin
                if (phase_end) begin
                    timer_restart = 1'b1;
                    if (!q.tck) begin
                        d.tck = 1'b1;
                    end else begin
                        d.tck = 1'b0;
                        if (all_issued) begin
                            d.state = ST_IDLE;
                            d.done  = 1'b1;
                        end else begin
                            d.tms = pick_tms;
                            d.tdi = pick_tdi;
                            d.idx = q.idx + CNT_W'(1);
                        end
                    end
                end
            end
            default: d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.state <= ST_IDLE;
            q.half  <= DIV_W'(1);
        end else begin
            q <= d;
        end
    end

    jbp_tck_timer #(.DIV_W(DIV_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (timer_restart),
        .half    (q.half),
        .expired (phase_end)
    );

    jbp_tdo_packer #(.AW(AW)) u_pack (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (accept),
        .cap_en (cap_en),
        .bit_i  (tdo),
        .last_i (all_issued),
        .we_o   (tx_we),
        .addr_o (tx_addr),
        .data_o (tx_data)
    );

    assign tck  = q.tck;
    assign tms  = q.tms;
    assign tdi  = q.tdi;
    assign done = q.done;
    assign busy = (q.state != ST_IDLE);

    // pattern pins move only while the test clock is low
    assert_tms_tck_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(q.tms) |-> !q.tck);
    assert_tdi_tck_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(q.tdi) |-> !q.tck);
    // end of run: single pulse, clock parked low, block idle
    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_done_parked_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!tck && !busy));
    // a start or divider change during a run leaves the latched run setup untouched
    assert_busy_ignore_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> ($stable(q.cnt) && $stable(q.half)));
    // every reply write coincides with a rising test clock
    assert_we_with_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
        tx_we |-> $rose(tck));
endmodule

// File: tb/jtag_bit_player_bench.sv
module jtag_bit_player_bench;
    localparam int BUF_BYTES = 124;
    localparam int DIV_W     = 8;
    localparam int AW        = $clog2(BUF_BYTES);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic [DIV_W-1:0] tck_half = '0;
    logic [AW-1:0]    rx_addr;
    logic [7:0]       rx_data;
    logic             tx_we;
    logic [AW-1:0]    tx_addr;
    logic [7:0]       tx_data;
    logic             tck, tms, tdi, tdo;
    logic             busy, done;

    logic [7:0] rxmem [0:(1<<AW)-1];
    logic [7:0] txmem [0:(1<<AW)-1];
    int rises = 0;
    int total = 0;
    int bad   = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    jtag_bit_player #(.BUF_BYTES(BUF_BYTES), .DIV_W(DIV_W)) u_jtag_bit_player (
        .clk(clk), .rst_n(rst_n), .start(start), .tck_half(tck_half),
        .rx_addr(rx_addr), .rx_data(rx_data),
        .tx_we(tx_we), .tx_addr(tx_addr), .tx_data(tx_data),
        .tck(tck), .tms(tms), .tdi(tdi), .tdo(tdo),
        .busy(busy), .done(done)
    );

    function automatic int pair_bits(int n, int k);
        return (k * 11 + n * 3 + 7) % 4;
    endfunction

    function automatic int tdo_pat(int k);
        return (((k * 5 + 1) % 7) < 3) ? 1 : 0;
    endfunction

    function automatic logic [7:0] exp_byte(int k);
        logic [7:0] b = 8'h00;
        for (int j = (k / 8) * 8; j <= k; j++)
            b[j % 8] = tdo_pat(j)[0];
        return b;
    endfunction

    assign rx_data = rxmem[rx_addr];
    assign tdo     = tdo_pat(rises)[0];

    always @(posedge tck) rises <= rises + 1;

    always @(posedge clk) if (tx_we) txmem[tx_addr] <= tx_data;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic run_case(input int n, input int hin, input int midt);
        int h, endt, last, k, ph, nb;
        bit eb, ed, et, ew;
        h = (hin == 0) ? 1 : hin;
        rxmem[0] = 8'(n);
        for (int i = 1; i < (1 << AW); i++) rxmem[i] = 8'h5A ^ 8'(i);
        for (int p = 0; p < n; p++) rxmem[1 + p / 4][2 * (p % 4) +: 2] = 2'(pair_bits(n, p));
        for (int i = 0; i < (1 << AW); i++) txmem[i] = 8'hEE;
        rises = 0;
        endt = 2 * h * n + 1;
        last = (n == 0) ? 2 : endt + 1;
        @(negedge clk);
        tck_half = DIV_W'(hin);
        start = 1'b1;
        @(posedge clk);
        for (int t = 0; t <= last; t++) begin
            @(negedge clk);
            eb = 0; ed = 0; et = 0; ew = 0; k = 0; ph = 0;
            if (t == 0) eb = 1;
            else if (n == 0) ed = (t == 1);
            else if (t < endt) begin
                eb = 1;
                k  = (t - 1) / (2 * h);
                ph = (t - 1) % (2 * h);
                et = (ph >= h);
                ew = (ph == h) && ((k % 8 == 7) || (k == n - 1));
            end else ed = (t == endt);
            chk(busy == eb, "R2 busy", busy, eb);
            chk(done == ed, "R8 done", done, ed);
            chk(tck == et, "R4 tck", tck, et);
            chk(tx_we == ew, "R7 tx_we", tx_we, ew);
            if (eb && n > 0 && t > 0) begin
                chk(tms == pair_bits(n, k)[1], "R3 tms", tms, pair_bits(n, k) / 2);
                chk(tdi == pair_bits(n, k)[0], "R5 tdi", tdi, pair_bits(n, k) % 2);
            end
            if (ew) begin
                chk(int'(tx_addr) == k / 8, "R7 tx_addr", tx_addr, k / 8);
                chk(tx_data == exp_byte(k), "R6 tx_data", tx_data, exp_byte(k));
            end
            // R10: stray start and divider change mid-run
            start = (t == midt);
            if (t == midt) tck_half = DIV_W'(hin + 5);
        end
        start = 1'b0;
        nb = (n + 7) / 8;
        for (int i = 0; i < nb; i++)
            chk(txmem[i] == exp_byte((8 * i + 7 < n) ? 8 * i + 7 : n - 1), "R7 reply byte",
                txmem[i], exp_byte((8 * i + 7 < n) ? 8 * i + 7 : n - 1));
        chk(txmem[nb] == 8'hEE, "R9 no extra write", txmem[nb], 8'hEE);
        chk(rises == n, "R4 tck rise count", rises, n);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!tck && !tms && !tdi, "R1 pins", {tck, tms, tdi}, 0);
        chk(!busy && !done && !tx_we, "R1 status", {busy, done, tx_we}, 0);
        run_case(0, 1, -1);   // R9
        run_case(5, 1, -1);
        run_case(9, 3, 4);    // R10 start during run, partial last byte
        run_case(8, 2, -1);   // full byte
        run_case(3, 0, 2);    // tck_half 0 acts as 1
        run_case(20, 2, 10);
        run_case(1, 4, -1);
        repeat (3) @(negedge clk);
        chk(!busy && !tck, "R8 idle after runs", {busy, tck}, 0);
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule